// File: doc/BRIEF.md
# Windowed Instruction Cache with Bus Bypass

This block is a direct-mapped instruction cache placed between a processor's instruction fetch port and external memory. Every fetch address is compared with a cacheable window given by two inputs, a lowest and a highest byte address, both inclusive. A fetch inside the window, with the cache switched on, is looked up in the tag store. A hit answers in the same cycle. A miss requests the whole line from memory over a dedicated refill link, writes the words into the line as they arrive, and then answers from the cache.

A fetch outside the window, or any fetch while the enable input is low, bypasses the cache. It goes to a plain bus port and leaves the cache contents untouched. A one-cycle invalidate pulse clears every valid bit, one line per cycle, and a busy output stays high while the pass is pending or running. The fetch side is a request/ready handshake. The requester holds the request and the address until ready is seen high.

Top module: `icache_window`

## Requirements
- R1: A fetch address A is cacheable when winBase <= A <= winHigh, both bounds inclusive. A fetch outside the window is completed on the bus port: busReq rises, fetchReady equals busAck, fetchData equals busData, and no refill is requested.
- R2: A fetch to a word of a resident line raises fetchReady in the same cycle as the request, with the stored word on fetchData. It causes no refill and no bus traffic.
- R3: On a miss, refAddr carries the line-aligned address (the low 4 bits are zero). The memory side then returns the 4 words of the line in ascending address order, one per cycle with refValid. After the last word the fetch is answered with the refilled word, and the other words of that line then hit.
- R4: Placement is direct-mapped over the offset O = A - winBase: the word number is O[3:2], the line index is O[9:4] (64 lines), and the tag is O[31:10]. Two addresses with the same index but different tags evict each other.
- R5: While cacheEn is low, every fetch, including fetches inside the window, goes to the bus port. Lines cached before stay valid and hit once cacheEn is high again.
- R6: The bus port holds busReq and busAddr = fetchAddr until busAck. busReq and refReq are never high together.
- R7: A one-cycle invalAll pulse received while idle keeps invalBusy high for exactly 64 cycles. After that, every previously resident line misses.
- R8: While invalBusy is high no cached fetch is answered. An invalAll that arrives during a refill is held until the refill ends, and the sweep then runs before the pending fetch is looked up again, so the fetch is refilled a second time.
- R9: After reset, fetchReady, refReq, busReq and invalBusy are low and all lines are invalid.
- R10: refReq stays high, with refAddr stable, until the first refill word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cacheEn | input | 1 | Cache enable; low routes all fetches to the bus |
| winBase | input | 32 | Lowest cacheable byte address (line aligned) |
| winHigh | input | 32 | Highest cacheable byte address |
| invalAll | input | 1 | One-cycle pulse requesting invalidation of all lines |
| invalBusy | output | 1 | Invalidation pending or running |
| fetchReq | input | 1 | Fetch request, held until fetchReady |
| fetchAddr | input | 32 | Fetch byte address |
| fetchReady | output | 1 | Fetch completes this cycle |
| fetchData | output | 32 | Instruction word, valid with fetchReady |
| refReq | output | 1 | Line refill request |
| refAddr | output | 32 | Line-aligned refill address |
| refValid | input | 1 | Refill word strobe |
| refData | input | 32 | Refill word |
| busReq | output | 1 | Bypass bus request |
| busAddr | output | 32 | Bypass bus address |
| busAck | input | 1 | Bypass bus completion |
| busData | input | 32 | Bypass bus read data |

## Verification
The hardest case to reach is an invalidate that lands while a refill is in flight. The fetch must survive the refill, the deferred sweep and a second refill of the same line, and no stale answer may appear in between. The bench starts a miss and pulses invalAll two cycles later, while the memory responder is still inside its latency. It then expects two refill requests, a wait longer than the sweep, and the correct word. A second corner pulses invalAll in the same cycle as a fetch to a resident line, to show that the sweep takes priority and that the hit is lost.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SWEEP  = 2'd1,
    S_FILL   = 2'd2,
    S_BYPASS = 2'd3
  } cacheState_e;

  typedef struct packed {
    logic startFill;
    logic writeWord;
    logic sweepStart;
    logic sweepLine;
  } ctrlStrobes_t;

endpackage

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cacheEn,
  input  logic         invalAll,
  input  logic         fetchReq,
  input  logic         inWindow,
  input  logic         hit,
  input  logic         fillLast,
  input  logic         sweepLast,
  input  logic         refValid,
  input  logic         busAck,
  output ctrlStrobes_t strobes,
  output logic         fetchReady,
  output logic         selBus,
  output logic         refReq,
  output logic         busReq,
  output logic         invalBusy
);

  cacheState_e stateQ, stateD;
  logic        pendQ;
  logic        wordSeenQ;
  logic        sweepWant;

  assign sweepWant = pendQ | invalAll;
  assign invalBusy = (stateQ == S_SWEEP) | pendQ;

  always_comb begin
    stateD     = stateQ;
    strobes    = '0;
    fetchReady = 1'b0;
    selBus     = 1'b0;
    refReq     = 1'b0;
    busReq     = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (sweepWant) begin
          stateD             = S_SWEEP;
          strobes.sweepStart = 1'b1;
        end else if (fetchReq) begin
          if (!cacheEn || !inWindow) begin
            stateD = S_BYPASS;
          end else if (hit) begin
            fetchReady = 1'b1;
          end else begin
            stateD            = S_FILL;
            strobes.startFill = 1'b1;
          end
        end
      end
      S_SWEEP: begin
        strobes.sweepLine = 1'b1;
        if (sweepLast) stateD = S_IDLE;
      end
      S_FILL: begin
        refReq = !wordSeenQ;
        if (refValid) begin
          strobes.writeWord = 1'b1;
          if (fillLast) stateD = S_IDLE;
        end
      end
      S_BYPASS: begin
        busReq     = 1'b1;
        selBus     = 1'b1;
        fetchReady = busAck;
        if (busAck) stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      pendQ     <= 1'b0;
      wordSeenQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_IDLE && sweepWant) pendQ <= 1'b0;
      else if (invalAll)                 pendQ <= 1'b1;
      if (strobes.startFill)                       wordSeenQ <= 1'b0;
      else if (stateQ == S_FILL && refValid)       wordSeenQ <= 1'b1;
    end
  end

endmodule

// File: rtl/icache_dpath.sv
module icache_dpath
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WPL    = 4,
  parameter int LINES  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winHigh,
  input  logic [DATA_W-1:0] refData,
  output logic              inWindow,
  output logic              hit,
  output logic [DATA_W-1:0] hitData,
  output logic [ADDR_W-1:0] refAddr,
  output logic              fillLast,
  output logic              sweepLast
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WRD_W  = $clog2(WPL);
  localparam int OFF_W  = BYTE_W + WRD_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int SLOTS  = LINES * WPL;

  logic [ADDR_W-1:0] offs;
  logic [WRD_W-1:0]  reqWord;
  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;

  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [SLOTS];
  logic [LINES-1:0]           lineValid;
  logic [LINES-1:0][WPL-1:0]  wordValid;

  logic [IDX_W-1:0]  fillIdx;
  logic [WRD_W-1:0]  fillCnt;
  logic [IDX_W-1:0]  sweepIdx;

  assign offs     = fetchAddr - winBase;
  assign reqWord  = offs[BYTE_W +: WRD_W];
  assign reqIdx   = offs[OFF_W +: IDX_W];
  assign reqTag   = offs[ADDR_W-1 -: TAG_W];
  assign inWindow = (fetchAddr >= winBase) && (fetchAddr <= winHigh);

  assign hit = lineValid[reqIdx] && wordValid[reqIdx][reqWord]
               && (tagMem[reqIdx] == reqTag);
  assign hitData   = dataMem[{reqIdx, reqWord}];
  assign fillLast  = (fillCnt == WRD_W'(WPL - 1));
  assign sweepLast = (sweepIdx == IDX_W'(LINES - 1));

  // per-line valid state
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic           lv;
    logic [WPL-1:0] wv;
    logic           clrHere;
    logic           wrHere;
    assign clrHere = (strobes.startFill && reqIdx == IDX_W'(l))
                   || (strobes.sweepLine && sweepIdx == IDX_W'(l));
    assign wrHere  = strobes.writeWord && (fillIdx == IDX_W'(l));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lv <= 1'b0;
        wv <= '0;
      end else if (clrHere) begin
        lv <= 1'b0;
        wv <= '0;
      end else if (wrHere) begin
        lv          <= 1'b1;
        wv[fillCnt] <= 1'b1;
      end
    end
    assign lineValid[l] = lv;
    assign wordValid[l] = wv;
  end

  // fill and sweep bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillIdx  <= '0;
      fillCnt  <= '0;
      sweepIdx <= '0;
      refAddr  <= '0;
    end else begin
      if (strobes.startFill) begin
        fillIdx <= reqIdx;
        fillCnt <= '0;
        refAddr <= winBase + {offs[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end else if (strobes.writeWord) begin
        fillCnt <= fillCnt + 1'b1;
      end
      if (strobes.sweepStart)     sweepIdx <= '0;
      else if (strobes.sweepLine) sweepIdx <= sweepIdx + 1'b1;
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    if (strobes.startFill) tagMem[reqIdx] <= reqTag;
    if (strobes.writeWord) dataMem[{fillIdx, fillCnt}] <= refData;
  end

endmodule

// File: rtl/icache_window.sv
module icache_window
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WPL    = 4,
  parameter int LINES  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winHigh,
  input  logic              invalAll,
  output logic              invalBusy,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [DATA_W-1:0] fetchData,
  output logic              refReq,
  output logic [ADDR_W-1:0] refAddr,
  input  logic              refValid,
  input  logic [DATA_W-1:0] refData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busData
);

  ctrlStrobes_t      strobes;
  logic              inWindow, hit, fillLast, sweepLast, selBus;
  logic [DATA_W-1:0] hitData;

  icache_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cacheEn   (cacheEn),
    .invalAll  (invalAll),
    .fetchReq  (fetchReq),
    .inWindow  (inWindow),
    .hit       (hit),
    .fillLast  (fillLast),
    .sweepLast (sweepLast),
    .refValid  (refValid),
    .busAck    (busAck),
    .strobes   (strobes),
    .fetchReady(fetchReady),
    .selBus    (selBus),
    .refReq    (refReq),
    .busReq    (busReq),
    .invalBusy (invalBusy)
  );

  icache_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WPL(WPL), .LINES(LINES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .fetchAddr(fetchAddr),
    .winBase  (winBase),
    .winHigh  (winHigh),
    .refData  (refData),
    .inWindow (inWindow),
    .hit      (hit),
    .hitData  (hitData),
    .refAddr  (refAddr),
    .fillLast (fillLast),
    .sweepLast(sweepLast)
  );

  assign busAddr   = fetchAddr;
  assign fetchData = selBus ? busData : hitData;

endmodule

// File: rtl/icache_window_chk.sv
module icache_window_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cacheEn,
  input logic [ADDR_W-1:0] winBase,
  input logic [ADDR_W-1:0] winHigh,
  input logic              invalAll,
  input logic              invalBusy,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchReady,
  input logic              refReq,
  input logic [ADDR_W-1:0] refAddr,
  input logic              refValid,
  input logic              busReq,
  input logic              busAck
);

  p_outside_bus_r1: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchReady && (fetchAddr < winBase || fetchAddr > winHigh) |-> busAck);

  p_disabled_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchReady && !cacheEn |-> busAck);

  p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq);

  p_port_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && refReq));

  p_ref_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> ((refAddr & ADDR_W'(LINE_BYTES - 1)) == '0));

  p_ref_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    refReq && !refValid |=> refReq && $stable(refAddr));

  p_inval_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    invalAll |=> invalBusy);

  p_no_hit_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    invalBusy && !busReq |-> !fetchReady);

endmodule

bind icache_window icache_window_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(WPL * DATA_W / 8)
) u_chk (
  .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .winBase(winBase),
  .winHigh(winHigh), .invalAll(invalAll), .invalBusy(invalBusy),
  .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchReady(fetchReady),
  .refReq(refReq), .refAddr(refAddr), .refValid(refValid),
  .busReq(busReq), .busAck(busAck)
);

// File: tb/tb_icache_window.sv
module tb_icache_window;

  localparam int CLK_P   = 10;
  localparam int LINES   = 64;
  localparam int REF_LAT = 3;
  localparam int BUS_LAT = 2;
  localparam int NVEC    = 13;

  localparam logic [31:0] BASE = 32'h4400_0000;
  localparam logic [31:0] HIGH = 32'h47FF_FFFF;

  // kind: 0 = hit, 1 = refill, 2 = bus
  localparam logic [31:0] V_ADDR [NVEC] = '{
    32'h4400_0000, 32'h4400_0004, 32'h4400_000C, 32'h4400_0010,
    32'h4400_001C, 32'h4400_0400, 32'h4400_0000, 32'h4000_0000,
    32'h4800_0000, 32'h47FF_FFFC, 32'h43FF_FFFC, 32'h4400_0004,
    32'h4400_0008 };
  localparam logic V_EN [NVEC] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1 };
  localparam logic [1:0] V_KIND [NVEC] = '{
    2'd1, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2, 2'd2, 2'd0 };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cacheEn = 1'b1;
  logic        invalAll = 1'b0;
  logic        invalBusy;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady;
  logic [31:0] fetchData;
  logic        refReq;
  logic [31:0] refAddr;
  logic        refValid = 1'b0;
  logic [31:0] refData = '0;
  logic        busReq;
  logic [31:0] busAddr;
  logic        busAck = 1'b0;
  logic [31:0] busData = '0;

  int checks = 0;
  int fails = 0;
  int fillCount = 0;
  int busCount = 0;
  logic [31:0] lastRefAddr = '0;

  always #(CLK_P / 2) clk = ~clk;

  icache_window dut (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .winBase(BASE), .winHigh(HIGH),
    .invalAll(invalAll), .invalBusy(invalBusy), .fetchReq(fetchReq),
    .fetchAddr(fetchAddr), .fetchReady(fetchReady), .fetchData(fetchData),
    .refReq(refReq), .refAddr(refAddr), .refValid(refValid), .refData(refData),
    .busReq(busReq), .busAddr(busAddr), .busAck(busAck), .busData(busData)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0F0F_1234;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // refill responder: ascending words after a fixed latency
  always begin
    @(negedge clk);
    if (refReq) begin
      lastRefAddr = refAddr;
      fillCount++;
      repeat (REF_LAT) @(negedge clk);
      for (int w = 0; w < 4; w++) begin
        refValid = 1'b1;
        refData  = memWord(lastRefAddr + 32'(4 * w));
        @(negedge clk);
      end
      refValid = 1'b0;
    end
  end

  // bypass bus responder
  always begin
    @(negedge clk);
    if (busReq) begin
      busCount++;
      repeat (BUS_LAT) @(negedge clk);
      busAck  = 1'b1;
      busData = ~busAddr;
      @(negedge clk);
      busAck = 1'b0;
    end
  end

  task automatic doFetch(input logic [31:0] a, input logic pulse,
                         output logic [31:0] d, output int waitCyc);
    @(negedge clk);
    fetchAddr = a;
    fetchReq  = 1'b1;
    invalAll  = pulse;
    waitCyc   = 0;
    fork
      begin @(posedge clk); #1 invalAll = 1'b0; end
    join_none
    #(CLK_P / 4);
    while (!fetchReady && waitCyc < 1000) begin
      #(CLK_P);
      waitCyc++;
    end
    d = fetchData;
    @(negedge clk);
    fetchReq = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int          w;
    int          f0, b0, busyCnt;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: idle outputs after reset
    chk("R9 fetchReady", 32'(fetchReady), 0);
    chk("R9 refReq",     32'(refReq),     0);
    chk("R9 busReq",     32'(busReq),     0);
    chk("R9 invalBusy",  32'(invalBusy),  0);

    for (int i = 0; i < NVEC; i++) begin
      cacheEn = V_EN[i];
      f0 = fillCount;
      b0 = busCount;
      doFetch(V_ADDR[i], 1'b0, d, w);
      if (V_KIND[i] == 2'd2) begin
        chk($sformatf("R1/R5/R6 bus data v%0d", i), d, ~V_ADDR[i]);
        chk($sformatf("R1/R5 bus count v%0d", i), 32'(busCount - b0), 1);
        chk($sformatf("R1 no refill v%0d", i), 32'(fillCount - f0), 0);
      end else begin
        chk($sformatf("R2/R3 data v%0d", i), d, memWord(V_ADDR[i]));
        chk($sformatf("R2 no bus v%0d", i), 32'(busCount - b0), 0);
        if (V_KIND[i] == 2'd0) begin
          chk($sformatf("R2 zero wait v%0d", i), 32'(w), 0);
          chk($sformatf("R2/R4/R5 no refill v%0d", i), 32'(fillCount - f0), 0);
        end else begin
          chk($sformatf("R3/R4/R9 refill v%0d", i), 32'(fillCount - f0), 1);
          chk($sformatf("R3/R10 ref addr v%0d", i), lastRefAddr,
              V_ADDR[i] & 32'hFFFF_FFF0);
        end
      end
    end
    cacheEn = 1'b1;

    // R7: idle invalidate lasts one cycle per line
    @(negedge clk);
    invalAll = 1'b1;
    @(negedge clk);
    invalAll = 1'b0;
    busyCnt = 0;
    while (invalBusy && busyCnt < 1000) begin
      busyCnt++;
      @(negedge clk);
    end
    chk("R7 busy cycles", 32'(busyCnt), LINES);
    f0 = fillCount;
    doFetch(32'h4400_0008, 1'b0, d, w);
    chk("R7 refill after sweep", 32'(fillCount - f0), 1);
    chk("R7 data after sweep", d, memWord(32'h4400_0008));

    // R8: invalidate together with a fetch to a resident line
    f0 = fillCount;
    doFetch(32'h4400_0008, 1'b1, d, w);
    chk("R8 stalled past sweep", 32'(w >= LINES), 1);
    chk("R8 refill after sweep", 32'(fillCount - f0), 1);
    chk("R8 data", d, memWord(32'h4400_0008));

    // R8: invalidate landing inside a refill
    f0 = fillCount;
    fork
      doFetch(32'h4400_0044, 1'b0, d, w);
      begin
        repeat (2) @(negedge clk);
        invalAll = 1'b1;
        @(negedge clk);
        invalAll = 1'b0;
      end
    join
    chk("R8 double refill", 32'(fillCount - f0), 2);
    chk("R8 wait longer than sweep", 32'(w > LINES), 1);
    chk("R8 data after deferred sweep", d, memWord(32'h4400_0044));
    chk("R10 ref addr", lastRefAddr, 32'h4400_0040);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule